// File: doc/BRIEF.md
# Frame Forwarding Decision with Qualified Static Override

This block chooses the egress ports for one received frame. Upstream logic has already looked up the frame's destination address in a static table and in a dynamic table, and has fetched the membership mask of the frame's VLAN. Those results arrive together with a request strobe. The block then produces a registered port mask with a one-cycle valid strobe.

A static entry takes precedence over a dynamic one, but only when the static entry is usable. An entry that does not ask for filter-ID qualification is always usable. An entry that does ask for it is usable only when its filter ID equals the frame's filter ID. If no static entry is usable, the dynamic hit forwards the frame to its single stored port. If neither table gives a usable hit, the frame is flooded to the VLAN members. Frames marked as errored and PAUSE frames are never forwarded. The ingress port is always removed from the result.

Top module: `fwd_decide`

## Requirements
- R1: While reset is high, and in the first cycle after it, `fwd_valid` is 0 and `fwd_mask` is all zeros.
- R2: `fwd_valid` is 1 in exactly the cycle after a cycle with `req_valid` high, and 0 in every other cycle.
- R3: A static hit with `st_use_fid` = 0 forwards to `st_ports`, whatever the frame's filter ID and whatever the dynamic lookup result.
- R4: A static hit with `st_use_fid` = 1 and `st_fid` equal to `frame_fid` forwards to `st_ports`, even when there is a dynamic hit.
- R5: A static hit with `st_use_fid` = 1 and `st_fid` different from `frame_fid` is ignored. The decision then uses the dynamic result, or the VLAN mask if there is no dynamic hit.
- R6: A dynamic hit with no usable static entry gives a one-hot mask. Port number n sets bit n (ports 0 to 4). A port number of 5 or more gives an empty mask.
- R7: With no usable static entry and no dynamic hit, the mask equals `vlan_members`.
- R8: A request with `err_frame` = 1 gives an all-zero mask, whatever the lookup results.
- R9: A request with `pause_frame` = 1 gives an all-zero mask, whatever the lookup results.
- R10: Bit `src_port` of the result is always 0. A `src_port` of 5 or more clears no bit.
- R11: `fwd_mask` stays unchanged from one request's result until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A decision is requested for the inputs presented this cycle |
| src_port | input | 3 | Ingress port number of the frame |
| err_frame | input | 1 | Frame has a framing, FCS, alignment or size error |
| pause_frame | input | 1 | Frame is a flow-control PAUSE frame |
| frame_fid | input | 7 | Filter ID of the frame's VLAN |
| st_hit | input | 1 | Destination was found in the static table |
| st_use_fid | input | 1 | Static entry is qualified by filter ID |
| st_fid | input | 7 | Filter ID stored in the static entry |
| st_ports | input | 5 | Port mask stored in the static entry |
| dy_hit | input | 1 | Destination plus filter ID was found in the dynamic table |
| dy_port | input | 3 | Port number stored in the dynamic entry |
| vlan_members | input | 5 | Membership mask of the frame's VLAN |
| fwd_valid | output | 1 | One-cycle strobe: a new decision is on `fwd_mask` |
| fwd_mask | output | 5 | Egress port mask, held until the next decision |

## Verification
The hardest case is a static entry that is present but rejected because its filter ID does not match. In that case the result must come from the dynamic table, or from the VLAN mask when the dynamic table also misses. From the ports this looks the same as an ordinary dynamic or flood decision. So the stimulus presents a static entry with a port mask that does not overlap the expected result, and then flips only the filter-ID relation. Any static leakage then shows up as a wrong mask. Source-port removal is checked on results from both the static path and the flood path. An out-of-range source number and an out-of-range dynamic port number are also exercised.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int NUM_PORTS = 5;
    localparam int PIDX_W    = 3;
    localparam int FID_W     = 7;

    typedef enum logic [1:0] {
        PICK_STATIC  = 2'd0,
        PICK_DYNAMIC = 2'd1,
        PICK_FLOOD   = 2'd2
    } fwd_pick_e;

    function automatic logic fid_accept(input logic use_fid,
                                        input logic [FID_W-1:0] entry_fid,
                                        input logic [FID_W-1:0] frame_fid);
        return !use_fid || (entry_fid == frame_fid);
    endfunction

endpackage

// File: rtl/fwd_port_decode.sv
module fwd_port_decode #(
    parameter int NUM_PORTS = fwd_pkg::NUM_PORTS,
    parameter int PIDX_W    = fwd_pkg::PIDX_W
) (
    input  logic [PIDX_W-1:0]    idx,
    output logic [NUM_PORTS-1:0] onehot
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_bit
        assign onehot[i] = (32'(idx) == i);
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
#(
    parameter int NUM_PORTS = fwd_pkg::NUM_PORTS,
    parameter int PIDX_W    = fwd_pkg::PIDX_W,
    parameter int FID_W     = fwd_pkg::FID_W
) (
    input  logic                 st_hit,
    input  logic                 st_use_fid,
    input  logic [FID_W-1:0]     st_fid,
    input  logic [FID_W-1:0]     frame_fid,
    input  logic [NUM_PORTS-1:0] st_ports,
    input  logic                 dy_hit,
    input  logic [PIDX_W-1:0]    dy_port,
    input  logic [NUM_PORTS-1:0] vlan_members,
    output fwd_pick_e            pick,
    output logic [NUM_PORTS-1:0] pick_mask
);
    logic                 st_usable;
    logic [NUM_PORTS-1:0] dy_mask;

    assign st_usable = st_hit && fid_accept(st_use_fid, st_fid, frame_fid);

    fwd_port_decode #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_dy_dec (
        .idx    (dy_port),
        .onehot (dy_mask)
    );

    always_comb begin
        if (st_usable)   pick = PICK_STATIC;
        else if (dy_hit) pick = PICK_DYNAMIC;
        else             pick = PICK_FLOOD;
    end

    always_comb begin
        unique case (pick)
            PICK_STATIC:  pick_mask = st_ports;
            PICK_DYNAMIC: pick_mask = dy_mask;
            default:      pick_mask = vlan_members;
        endcase
    end
endmodule

// File: rtl/fwd_decide.sv
module fwd_decide
    import fwd_pkg::*;
#(
    parameter int NUM_PORTS = fwd_pkg::NUM_PORTS,
    parameter int PIDX_W    = fwd_pkg::PIDX_W,
    parameter int FID_W     = fwd_pkg::FID_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [PIDX_W-1:0]    src_port,
    input  logic                 err_frame,
    input  logic                 pause_frame,
    input  logic [FID_W-1:0]     frame_fid,
    input  logic                 st_hit,
    input  logic                 st_use_fid,
    input  logic [FID_W-1:0]     st_fid,
    input  logic [NUM_PORTS-1:0] st_ports,
    input  logic                 dy_hit,
    input  logic [PIDX_W-1:0]    dy_port,
    input  logic [NUM_PORTS-1:0] vlan_members,
    output logic                 fwd_valid,
    output logic [NUM_PORTS-1:0] fwd_mask
);
    fwd_pick_e            pick;
    logic [NUM_PORTS-1:0] pick_mask;
    logic [NUM_PORTS-1:0] src_bit;
    logic                 drop;

    fwd_pick #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W), .FID_W(FID_W)) u_pick (
        .st_hit       (st_hit),
        .st_use_fid   (st_use_fid),
        .st_fid       (st_fid),
        .frame_fid    (frame_fid),
        .st_ports     (st_ports),
        .dy_hit       (dy_hit),
        .dy_port      (dy_port),
        .vlan_members (vlan_members),
        .pick         (pick),
        .pick_mask    (pick_mask)
    );

    fwd_port_decode #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_src_dec (
        .idx    (src_port),
        .onehot (src_bit)
    );

    assign drop = err_frame || pause_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid <= 1'b0;
            fwd_mask  <= '0;
        end else begin
            fwd_valid <= req_valid;
            if (req_valid) begin
                fwd_mask <= drop ? '0 : (pick_mask & ~src_bit);
            end
        end
    end
endmodule

// File: rtl/fwd_decide_checker.sv
module fwd_decide_checker #(
    parameter int NUM_PORTS = fwd_pkg::NUM_PORTS,
    parameter int PIDX_W    = fwd_pkg::PIDX_W,
    parameter int FID_W     = fwd_pkg::FID_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [PIDX_W-1:0]    src_port,
    input logic                 err_frame,
    input logic                 pause_frame,
    input logic [FID_W-1:0]     frame_fid,
    input logic                 st_hit,
    input logic                 st_use_fid,
    input logic [FID_W-1:0]     st_fid,
    input logic [NUM_PORTS-1:0] st_ports,
    input logic                 dy_hit,
    input logic [NUM_PORTS-1:0] vlan_members,
    input logic                 fwd_valid,
    input logic [NUM_PORTS-1:0] fwd_mask
);
    logic clean;
    assign clean = req_valid && !err_frame && !pause_frame;

    AST_STROBE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> fwd_valid); // R2
    AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !fwd_valid); // R2
    AST_ERR_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && err_frame) |=> (fwd_mask == '0)); // R8
    AST_PAUSE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pause_frame) |=> (fwd_mask == '0)); // R9
    AST_SRC_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (32'(src_port) < NUM_PORTS)) |=>
        ((fwd_mask & (NUM_PORTS'(1) << $past(src_port))) == '0)); // R10
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(fwd_mask)); // R11
    AST_STATIC_UNQUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (clean && st_hit && !st_use_fid) |=> ((fwd_mask & ~$past(st_ports)) == '0)); // R3
    AST_STATIC_FID_MATCH: assert property (@(posedge clk) disable iff (rst)
        (clean && st_hit && st_use_fid && (st_fid == frame_fid)) |=>
        ((fwd_mask & ~$past(st_ports)) == '0)); // R4
    AST_DYNAMIC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (clean && dy_hit && !(st_hit && (!st_use_fid || st_fid == frame_fid))) |=>
        $onehot0(fwd_mask)); // R6
    AST_FLOOD_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (clean && !dy_hit && !st_hit) |=> ((fwd_mask & ~$past(vlan_members)) == '0)); // R7
endmodule

bind fwd_decide fwd_decide_checker #(
    .NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W), .FID_W(FID_W)
) u_fwd_decide_checker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .src_port     (src_port),
    .err_frame    (err_frame),
    .pause_frame  (pause_frame),
    .frame_fid    (frame_fid),
    .st_hit       (st_hit),
    .st_use_fid   (st_use_fid),
    .st_fid       (st_fid),
    .st_ports     (st_ports),
    .dy_hit       (dy_hit),
    .vlan_members (vlan_members),
    .fwd_valid    (fwd_valid),
    .fwd_mask     (fwd_mask)
);

// File: tb/fwd_decide_bench.sv
module fwd_decide_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] src_port = 3'd7;
    logic       err_frame = 1'b0;
    logic       pause_frame = 1'b0;
    logic [6:0] frame_fid = '0;
    logic       st_hit = 1'b0;
    logic       st_use_fid = 1'b0;
    logic [6:0] st_fid = '0;
    logic [4:0] st_ports = '0;
    logic       dy_hit = 1'b0;
    logic [2:0] dy_port = '0;
    logic [4:0] vlan_members = '0;
    logic       fwd_valid;
    logic [4:0] fwd_mask;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fwd_decide u_fwd_decide (
        .clk(clk), .rst(rst), .req_valid(req_valid), .src_port(src_port),
        .err_frame(err_frame), .pause_frame(pause_frame), .frame_fid(frame_fid),
        .st_hit(st_hit), .st_use_fid(st_use_fid), .st_fid(st_fid), .st_ports(st_ports),
        .dy_hit(dy_hit), .dy_port(dy_port), .vlan_members(vlan_members),
        .fwd_valid(fwd_valid), .fwd_mask(fwd_mask)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        src_port = 3'd7; err_frame = 0; pause_frame = 0; frame_fid = '0;
        st_hit = 0; st_use_fid = 0; st_fid = '0; st_ports = '0;
        dy_hit = 0; dy_port = '0; vlan_members = '0;
    endtask

    // Inputs are already set; this task fires one request and checks the result.
    task automatic fire(input string req, input logic [4:0] exp);
        req_valid = 1'b1;
        @(negedge clk);
        check("R2 strobe", {4'b0, fwd_valid}, 5'b1);
        check(req, fwd_mask, exp);
        req_valid = 1'b0;
        clear_inputs();
        @(negedge clk);
        check("R2 strobe low", {4'b0, fwd_valid}, 5'b0);
        check("R11 hold", fwd_mask, exp);
    endtask

    task automatic t_reset();
        check("R1 valid", {4'b0, fwd_valid}, 5'b0);
        check("R1 mask", fwd_mask, 5'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after", {4'b0, fwd_valid}, 5'b0);
        check("R1 mask after", fwd_mask, 5'b0);
    endtask

    task automatic t_static_plain();
        st_hit = 1; st_use_fid = 0; st_fid = 7'd3; frame_fid = 7'd9;
        st_ports = 5'b10110; dy_hit = 1; dy_port = 3'd0; vlan_members = 5'b11111;
        fire("R3 static unqualified", 5'b10110);
    endtask

    task automatic t_static_fid_match();
        st_hit = 1; st_use_fid = 1; st_fid = 7'd42; frame_fid = 7'd42;
        st_ports = 5'b01001; dy_hit = 1; dy_port = 3'd2; vlan_members = 5'b11111;
        fire("R4 static fid match", 5'b01001);
    endtask

    task automatic t_static_fid_miss();
        st_hit = 1; st_use_fid = 1; st_fid = 7'd42; frame_fid = 7'd43;
        st_ports = 5'b00111; dy_hit = 1; dy_port = 3'd3; vlan_members = 5'b11111;
        fire("R5 fid miss to dynamic", 5'b01000);
        st_hit = 1; st_use_fid = 1; st_fid = 7'd1; frame_fid = 7'd2;
        st_ports = 5'b00011; dy_hit = 0; vlan_members = 5'b11100;
        fire("R5 fid miss to flood", 5'b11100);
    endtask

    task automatic t_dynamic();
        dy_hit = 1; dy_port = 3'd0; vlan_members = 5'b11110;
        fire("R6 dynamic port 0", 5'b00001);
        dy_hit = 1; dy_port = 3'd4; vlan_members = 5'b00001;
        fire("R6 dynamic port 4", 5'b10000);
        dy_hit = 1; dy_port = 3'd6; vlan_members = 5'b11111;
        fire("R6 dynamic out of range", 5'b00000);
    endtask

    task automatic t_flood();
        vlan_members = 5'b10101;
        fire("R7 flood", 5'b10101);
    endtask

    task automatic t_drops();
        err_frame = 1; st_hit = 1; st_ports = 5'b11111; vlan_members = 5'b11111;
        fire("R8 error frame", 5'b00000);
        pause_frame = 1; dy_hit = 1; dy_port = 3'd1; vlan_members = 5'b11111;
        fire("R9 pause frame", 5'b00000);
    endtask

    task automatic t_source_clear();
        src_port = 3'd2; vlan_members = 5'b11111;
        fire("R10 flood minus source", 5'b11011);
        src_port = 3'd1; st_hit = 1; st_ports = 5'b00110;
        fire("R10 static minus source", 5'b00100);
        src_port = 3'd3; dy_hit = 1; dy_port = 3'd3;
        fire("R10 dynamic to source", 5'b00000);
    endtask

    task automatic t_hold();
        vlan_members = 5'b01110;
        fire("R7 flood before hold", 5'b01110);
        for (int i = 0; i < 6; i++) begin
            st_hit = 1; st_ports = 5'(i + 1); vlan_members = 5'(~i);
            @(negedge clk);
            check("R11 held without request", fwd_mask, 5'b01110);
            check("R2 no strobe", {4'b0, fwd_valid}, 5'b0);
        end
        clear_inputs();
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_static_plain();
        t_static_fid_match();
        t_static_fid_miss();
        t_dynamic();
        t_flood();
        t_drops();
        t_source_clear();
        t_hold();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule